// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Address-Frame Filtering

This block sends and receives asynchronous serial characters over a single transmit line and a single receive line. A programmable divider sets the rate of oversampling ticks. Each bit lasts sixteen ticks, or eight when the double-speed control is set in asynchronous mode. Characters carry 8 or 9 data bits. In 9-bit mode the extra bit can mark address frames: with address filtering enabled, the receiver keeps only frames whose ninth bit is 1.

The host side looks like a register: level control inputs, a write strobe carrying a data byte, and a separate ninth-bit input that is captured at that strobe. The receive side presents the received byte, its ninth bit and a frame-error flag, together with a one-cycle valid pulse. A one-entry buffer sits in front of the transmit shift register. The transmitter keeps the output line while enabled or while data is still queued. When it has fully stopped, the line follows a plain port value. A 2-bit mode field is decoded, but only asynchronous framing is built.

Top module: `uart_mp`

## Requirements
- R1: Clearing `tx_en` does not stop transmission. Any character in the shift register and any character in the buffer are still sent in full. `tx_owns_line` stays 1 until both are empty.
- R2: When `tx_en` is 0 and nothing is queued or shifting, including after reset, `txd` equals `port_txd`.
- R3: One bit lasts 16 ticks. With `mode_sel` = 00 and `dbl_speed` = 1 it lasts 8 ticks. One tick is `baud_div`+1 clock cycles.
- R4: `mode_sel` encodes 00 = asynchronous, 01 = synchronous, 10 = infrared and 11 = master SPI. For any value other than 00, `dbl_speed` has no effect and bits last 16 ticks.
- R5: With `nine_bit` = 1, the ninth transmitted bit is the value of `tx_bit8` at the cycle of the `tx_wr` strobe. Later changes to `tx_bit8` do not alter that character.
- R6: With `mp_mode` = 1, a received frame whose ninth bit is 0 gives no `rx_valid` pulse and leaves `rx_data`, `rx_bit8` and `rx_frame_err` unchanged. In 8-bit mode the ninth bit counts as 0. Frames whose ninth bit is 1 are delivered.
- R7: A frame is a low start bit, then the data bits least significant first (bit 8 last in 9-bit mode), then a high stop bit. The receiver detects the falling start edge, confirms it at mid-bit, and samples each bit at its middle tick. It delivers the byte on `rx_data` and the ninth bit on `rx_bit8`, which reads 0 in 8-bit mode.
- R8: A stop bit sampled as 0 sets `rx_frame_err` for that character. A stop bit sampled as 1 clears it.
- R9: After reset `tx_buf_empty` is 1. A `tx_wr` with `tx_en` = 1 and the buffer empty is accepted and clears `tx_buf_empty`. A `tx_wr` while the buffer is full is ignored, and that character is never sent.
- R10: `rx_valid` is a single-cycle pulse for each delivered frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Communication mode field (00 async, 01 sync, 10 infrared, 11 master SPI) |
| tx_en | input | 1 | Transmitter enable |
| dbl_speed | input | 1 | Halve ticks per bit (asynchronous mode only) |
| mp_mode | input | 1 | Receive address frames only |
| nine_bit | input | 1 | 9-bit characters when 1, 8-bit when 0 |
| tx_bit8 | input | 1 | Ninth transmit bit, captured on tx_wr |
| baud_div | input | DIV_W | Tick divider; tick period is baud_div+1 clocks |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | 8 | Transmit data byte |
| port_txd | input | 1 | Line value used when the transmitter releases txd |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_owns_line | output | 1 | Transmitter is driving txd |
| tx_buf_empty | output | 1 | Transmit buffer can accept a write |
| tx_busy | output | 1 | Shift register is sending a frame |
| rx_data | output | 8 | Last delivered received byte |
| rx_bit8 | output | 1 | Ninth bit of the last delivered frame |
| rx_valid | output | 1 | One-cycle pulse when a frame is delivered |
| rx_frame_err | output | 1 | Stop bit of the last delivered frame was 0 |

## Verification
Some rules are checked by assertions on every cycle. A write into a full buffer must leave the buffered character untouched. A load must empty the buffer and start the shifter. The idle shifter must hold the line high. Every delivery made with address filtering on must carry a ninth bit of 1. Valid must never last two cycles. Ownership may only drop once both transmit stages are empty. Other behaviour only shows in the bench scenarios. These are bit durations in clock cycles for each mode and speed combination, least-significant-first order on a line driven independently of the transmitter, and ninth-bit capture at the strobe. The bench also covers frame-error reporting, a disable that still drains two queued characters, and discarded data frames leaving the receive outputs as they were.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_IR    = 2'b10,
    MODE_MSPI  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  localparam int OSR_W = 5;
  localparam int BITCNT_W = 4;

  // ticks per bit: halved only for asynchronous double speed
  function automatic logic [OSR_W-1:0] osr_of(input logic [1:0] mode, input logic dbl);
    return (mode == MODE_ASYNC && dbl) ? OSR_W'(8) : OSR_W'(16);
  endfunction

  // start + data + stop
  function automatic logic [BITCNT_W-1:0] tx_frame_bits(input logic nine);
    return nine ? BITCNT_W'(11) : BITCNT_W'(10);
  endfunction

  function automatic logic [BITCNT_W-1:0] rx_data_bits(input logic nine);
    return nine ? BITCNT_W'(9) : BITCNT_W'(8);
  endfunction
endpackage

// File: rtl/uart_mp_tick.sv
module uart_mp_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_mp_tx.sv
module uart_mp_tx
  import uart_mp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [OSR_W-1:0] osr,
  input  logic             tx_en,
  input  logic             nine_bit,
  input  logic             tx_bit8,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             buf_empty,
  output logic             busy,
  output logic             line
);
  localparam int SH_W = 11;

  logic                buf_full;
  logic [8:0]          buf_q;
  logic [SH_W-1:0]     shreg;
  logic [BITCNT_W-1:0] bits_left;
  logic [OSR_W-1:0]    samp;
  logic                load;
  logic                wr_ok;
  logic                bit_end;

  assign wr_ok     = tx_wr && tx_en && !buf_full;
  assign load      = !busy && buf_full;
  assign bit_end   = busy && tick && (samp >= osr - OSR_W'(1));
  assign buf_empty = !buf_full;
  assign line      = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full  <= 1'b0;
      buf_q     <= '0;
      shreg     <= '1;
      bits_left <= '0;
      samp      <= '0;
      busy      <= 1'b0;
    end else begin
      if (wr_ok) begin
        buf_full <= 1'b1;
        buf_q    <= {tx_bit8, tx_data};
      end
      if (load) begin
        buf_full  <= 1'b0;
        busy      <= 1'b1;
        samp      <= '0;
        bits_left <= tx_frame_bits(nine_bit);
        shreg     <= {1'b1, (nine_bit ? buf_q[8] : 1'b1), buf_q[7:0], 1'b0};
      end else if (bit_end) begin
        samp      <= '0;
        shreg     <= {1'b1, shreg[SH_W-1:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == BITCNT_W'(1)) busy <= 1'b0;
      end else if (busy && tick) begin
        samp <= samp + 1'b1;
      end
    end
  end

  a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && buf_full |=> $stable(buf_q));
  a_r9_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && !buf_full);
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [OSR_W-1:0] osr,
  input  logic             nine_bit,
  input  logic             mp_mode,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_bit8,
  output logic             rx_frame_err,
  output logic             rx_valid
);
  rx_state_e           state;
  logic                rx_s1, rx_s2, rx_s3;
  logic [OSR_W-1:0]    samp;
  logic [BITCNT_W-1:0] bit_cnt;
  logic [8:0]          sh;
  logic [OSR_W-1:0]    half;
  logic                fall_edge;
  logic                mid_start;
  logic                mid_bit;
  logic                frame_b8;
  logic [7:0]          frame_data;
  logic                keep;

  assign half       = osr >> 1;
  assign fall_edge  = rx_s3 && !rx_s2;
  assign mid_start  = tick && (samp >= half - OSR_W'(1));
  assign mid_bit    = tick && (samp >= osr - OSR_W'(1));
  assign frame_b8   = nine_bit ? sh[8] : 1'b0;
  assign frame_data = nine_bit ? sh[7:0] : sh[8:1];
  assign keep       = !mp_mode || frame_b8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
      rx_s3 <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      rx_s3 <= rx_s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= RX_IDLE;
      samp         <= '0;
      bit_cnt      <= '0;
      sh           <= '0;
      rx_data      <= '0;
      rx_bit8      <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_valid     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        RX_IDLE: if (fall_edge) begin
          state <= RX_START;
          samp  <= '0;
        end
        RX_START: if (mid_start) begin
          samp    <= '0;
          bit_cnt <= '0;
          state   <= rx_s2 ? RX_IDLE : RX_DATA;
        end else if (tick) samp <= samp + 1'b1;
        RX_DATA: if (mid_bit) begin
          samp <= '0;
          sh   <= {rx_s2, sh[8:1]};
          if (bit_cnt == rx_data_bits(nine_bit) - BITCNT_W'(1)) state <= RX_STOP;
          else bit_cnt <= bit_cnt + 1'b1;
        end else if (tick) samp <= samp + 1'b1;
        RX_STOP: if (mid_bit) begin
          state <= RX_IDLE;
          if (keep) begin
            rx_valid     <= 1'b1;
            rx_data      <= frame_data;
            rx_bit8      <= frame_b8;
            rx_frame_err <= !rx_s2;
          end
        end else if (tick) samp <= samp + 1'b1;
        default: state <= RX_IDLE;
      endcase
    end
  end

  a_r6_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!$past(mp_mode) || rx_bit8));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/uart_mp.sv
module uart_mp
  import uart_mp_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             tx_en,
  input  logic             dbl_speed,
  input  logic             mp_mode,
  input  logic             nine_bit,
  input  logic             tx_bit8,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  input  logic             port_txd,
  input  logic             rxd,
  output logic             txd,
  output logic             tx_owns_line,
  output logic             tx_buf_empty,
  output logic             tx_busy,
  output logic [7:0]       rx_data,
  output logic             rx_bit8,
  output logic             rx_valid,
  output logic             rx_frame_err
);
  logic             tick;
  logic [OSR_W-1:0] osr;
  logic             tx_line;

  assign osr          = osr_of(mode_sel, dbl_speed);
  assign tx_owns_line = tx_en || tx_busy || !tx_buf_empty;
  assign txd          = tx_owns_line ? tx_line : port_txd;

  uart_mp_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  uart_mp_tx tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osr(osr), .tx_en(tx_en),
    .nine_bit(nine_bit), .tx_bit8(tx_bit8), .tx_wr(tx_wr), .tx_data(tx_data),
    .buf_empty(tx_buf_empty), .busy(tx_busy), .line(tx_line)
  );

  uart_mp_rx rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osr(osr), .nine_bit(nine_bit),
    .mp_mode(mp_mode), .rxd(rxd), .rx_data(rx_data), .rx_bit8(rx_bit8),
    .rx_frame_err(rx_frame_err), .rx_valid(rx_valid)
  );

  a_r1_release_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_owns_line) |-> !tx_busy && tx_buf_empty && !tx_en);
endmodule

// File: tb/uart_mp_tb_top.sv
module uart_mp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 12;
  localparam int DIV = 1;
  localparam int BIT_CLK = 16 * (DIV + 1);
  localparam int NVEC = 9;
  // {nine_bit, mp_mode, dbl_speed, tx_bit8, data[7:0], expect_delivered}
  localparam logic [12:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b1},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h81, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h7E, 1'b1},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h42, 1'b1},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h99, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h11, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h55, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'hC3, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic tx_en = 1'b0, dbl_speed = 1'b0, mp_mode = 1'b0, nine_bit = 1'b0, tx_bit8 = 1'b0;
  logic [DIV_W-1:0] baud_div = DIV_W'(DIV);
  logic tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic port_txd = 1'b0;
  logic loop_sel = 1'b0;
  logic rxd_drv = 1'b1;
  logic rxd;
  logic txd, tx_owns_line, tx_buf_empty, tx_busy, rx_bit8, rx_valid, rx_frame_err;
  logic [7:0] rx_data;

  int checks = 0;
  int fails = 0;

  assign rxd = loop_sel ? txd : rxd_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_mp #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tx_en(tx_en), .dbl_speed(dbl_speed),
    .mp_mode(mp_mode), .nine_bit(nine_bit), .tx_bit8(tx_bit8), .baud_div(baud_div),
    .tx_wr(tx_wr), .tx_data(tx_data), .port_txd(port_txd), .rxd(rxd), .txd(txd),
    .tx_owns_line(tx_owns_line), .tx_buf_empty(tx_buf_empty), .tx_busy(tx_busy),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_rx(input int limit, output bit got);
    got = 1'b0;
    for (int i = 0; i < limit && !got; i++) begin
      @(negedge clk);
      if (rx_valid) got = 1'b1;
    end
  endtask

  task automatic wait_tx_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!tx_busy && tx_buf_empty) break;
    end
  endtask

  task automatic write_tx(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic send_raw(input logic [8:0] bits, input int nb, input logic stopv);
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      rxd_drv = bits[b];
      repeat (BIT_CLK) @(negedge clk);
    end
    rxd_drv = stopv;
    repeat (BIT_CLK) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
  endtask

  task automatic measure_start(output int n);
    n = 0;
    for (int i = 0; i < 200 && txd; i++) @(negedge clk);
    while (!txd && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    int n;
    logic [7:0] last_data;
    repeat (4) @(negedge clk);
    // reset state
    chk(txd == 1'b0, "R2 reset txd follows port", txd, 0);
    chk(tx_buf_empty == 1'b1, "R9 reset buffer empty", tx_buf_empty, 1);
    chk(rx_valid == 1'b0, "R10 reset no valid", rx_valid, 0);
    port_txd = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R2 txd follows port", txd, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    loop_sel = 1'b1;
    tx_en = 1'b1;
    last_data = 8'h00;

    // table walk, loopback
    for (int i = 0; i < NVEC; i++) begin
      logic [12:0] v;
      v = VECS[i];
      @(negedge clk);
      nine_bit = v[12]; mp_mode = v[11]; dbl_speed = v[10];
      tx_bit8 = v[9];
      write_tx(v[8:1]);
      tx_bit8 = ~v[9];
      wait_rx(900, got);
      if (v[0]) begin
        chk(got, "R6 R7 frame delivered", got, 1);
        chk(rx_data == v[8:1], "R7 data", rx_data, v[8:1]);
        chk(rx_bit8 == (v[12] & v[9]), "R5 ninth bit", rx_bit8, v[12] & v[9]);
        chk(rx_frame_err == 1'b0, "R8 good stop", rx_frame_err, 0);
        @(negedge clk);
        chk(rx_valid == 1'b0, "R10 single pulse", rx_valid, 0);
        last_data = v[8:1];
      end else begin
        chk(!got, "R6 data frame dropped", got, 0);
        chk(rx_data == last_data, "R6 outputs unchanged", rx_data, last_data);
      end
      wait_tx_idle();
    end
    nine_bit = 1'b0; mp_mode = 1'b0; dbl_speed = 1'b0;
    repeat (BIT_CLK) @(negedge clk);

    // bit durations
    write_tx(8'h01);
    measure_start(n);
    chk(n >= BIT_CLK - 1 && n <= BIT_CLK, "R3 normal bit time", n, BIT_CLK);
    wait_tx_idle();
    dbl_speed = 1'b1;
    write_tx(8'h01);
    measure_start(n);
    chk(n >= BIT_CLK/2 - 1 && n <= BIT_CLK/2, "R3 double speed bit time", n, BIT_CLK/2);
    wait_tx_idle();
    mode_sel = 2'b01;
    write_tx(8'h01);
    measure_start(n);
    chk(n >= BIT_CLK - 1 && n <= BIT_CLK, "R4 dbl ignored outside async", n, BIT_CLK);
    wait_rx(900, got);
    chk(got && rx_data == 8'h01, "R4 frame in mode 01", rx_data, 1);
    wait_tx_idle();
    mode_sel = 2'b00; dbl_speed = 1'b0;
    repeat (BIT_CLK) @(negedge clk);

    // deferred disable and ignored write
    write_tx(8'h6B);
    write_tx(8'hD2);
    chk(tx_buf_empty == 1'b0, "R9 buffer full", tx_buf_empty, 0);
    write_tx(8'hEE);
    tx_en = 1'b0;
    @(negedge clk);
    chk(tx_owns_line == 1'b1, "R1 still owns while draining", tx_owns_line, 1);
    wait_rx(900, got);
    chk(got && rx_data == 8'h6B, "R1 first drained", rx_data, 8'h6B);
    wait_rx(900, got);
    chk(got && rx_data == 8'hD2, "R1 second drained", rx_data, 8'hD2);
    wait_rx(900, got);
    chk(!got, "R9 write while full ignored", got, 0);
    chk(tx_owns_line == 1'b0, "R1 released after drain", tx_owns_line, 0);
    loop_sel = 1'b0;
    port_txd = 1'b0;
    @(negedge clk);
    chk(txd == 1'b0, "R2 released txd follows port", txd, 0);
    port_txd = 1'b1;
    repeat (4) @(negedge clk);

    // raw-driven receive: bit order and stop errors
    fork
      send_raw(9'h035, 8, 1'b1);
      wait_rx(900, got);
    join
    chk(got && rx_data == 8'h35, "R7 lsb first receive", rx_data, 8'h35);
    chk(rx_frame_err == 1'b0, "R8 stop high", rx_frame_err, 0);
    fork
      send_raw(9'h0C6, 8, 1'b0);
      wait_rx(900, got);
    join
    chk(got && rx_data == 8'hC6, "R8 data with bad stop", rx_data, 8'hC6);
    chk(rx_frame_err == 1'b1, "R8 stop low flagged", rx_frame_err, 1);
    nine_bit = 1'b1; mp_mode = 1'b1;
    fork
      send_raw(9'h15A, 9, 1'b1);
      wait_rx(900, got);
    join
    chk(got && rx_data == 8'h5A && rx_bit8, "R6 address frame kept", rx_data, 8'h5A);
    fork
      send_raw(9'h077, 9, 1'b0);
      wait_rx(900, got);
    join
    chk(!got, "R6 raw data frame dropped", got, 0);
    chk(rx_data == 8'h5A && rx_frame_err == 1'b0, "R6 outputs kept", rx_data, 8'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule